// File: doc/BRIEF.md
# Viterbi Butterfly Add-Compare-Select Engine

This block performs the path-metric update for a 16-state, rate-1/2, soft-decision Viterbi decoder. Each accepted symbol carries two 3-bit signed soft values. The block forms the two correlation branch metrics from them. All eight butterflies of the trellis stage then run in parallel within a single clock cycle. The engine keeps the path metrics that survive, choosing the larger candidate at each state. It also records one survivor decision bit per state.

The path metrics live in two register banks that take turns. One bank supplies the previous stage and the other receives the new stage, and the roles swap after every symbol. The sixteen decisions of a stage are packed into one 16-bit transition word in a fixed interleaved state order. A later traceback stage stores this word. A combinational read port returns the metric of any state after the latest symbol, so the caller can choose a final state.

Asserting `frame_start` together with a symbol makes that symbol start from the initial metrics instead of the banked ones. The block accepts a new symbol on every clock.

Top module: `vit_acs_engine`

## Requirements
- R1: `sd0` and `sd1` are 3-bit two's-complement values, so code 011 is +3 and code 100 is -4. The branch metrics are sum = sd0+sd1 and diff = sd0-sd1, and the other two branches use their negations.
- R2: Butterfly J (J = 0..7) takes old states 2J and 2J+1 and produces new states J and J+8. Butterflies 0-3 use m = sum and butterflies 4-7 use m = diff. An even J is direct: new(J) takes old(2J)+m or old(2J+1)-m, and new(J+8) takes old(2J)-m or old(2J+1)+m. An odd J is reverse, with every sign of m flipped.
- R3: Each new metric is the larger of its two candidates, compared as signed values. On a tie the candidate from old state 2J is kept and the decision bit is 0.
- R4: A decision bit is 1 when the candidate from old state 2J+1 wins. The decision for new state J sits at trn_word bit 15-2J and the decision for new state J+8 at bit 14-2J. Read from MSB to LSB, the word therefore lists states 0,8,1,9,...,7,15.
- R5: `trn_valid` is high in exactly the cycle after each cycle with `sym_valid` high, and it is low after reset.
- R6: For a symbol accepted with `frame_start`, the old metric of state 0 is 0 and the old metric of every other state is -32768 (0x8000). After reset the banked metrics hold these same values.
- R7: Adding or subtracting a branch metric saturates to the 16-bit signed range [-32768, 32767] and never wraps.
- R8: `rd_metric` gives, in the same cycle, the metric of state `rd_state` produced by the most recent symbol. That symbol's metrics become the old metrics of the next symbol, and they do not change while no symbol is accepted.
- R9: `trn_word` keeps its value in every cycle that follows a cycle without `sym_valid`, and it reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol pair is present this cycle |
| frame_start | input | 1 | The present symbol starts a frame from the initial metrics |
| sd0 | input | 3 | First soft value, two's complement |
| sd1 | input | 3 | Second soft value, two's complement |
| rd_state | input | 4 | State whose metric is read |
| rd_metric | output | 16 | Signed metric of `rd_state` after the latest symbol |
| trn_valid | output | 1 | Transition word updated by the previous cycle's symbol |
| trn_word | output | 16 | Packed survivor decisions of the latest symbol |

## Verification
The bound checker watches several properties on every clock. It checks the one-cycle timing of `trn_valid`. It checks that the transition word and the read metrics hold across idle cycles. It checks that the first symbol of a frame never picks an odd predecessor for states 0 and 8. It also checks that zero-difference symbols at frame start produce all-tie zero decisions in the lower butterflies.

The exact metric arithmetic needs longer symbol sequences, which only the bench's scenarios drive. This covers the direct and reverse alternation, the sum and diff split, and the interleaved bit order. It also covers saturation at the positive limit, which takes thousands of symbols, and a frame restart in the middle of a stream. For these the bench's reference model compares every output in every cycle.

// File: rtl/vit_acs_pkg.sv
package vit_acs_pkg;

    // Configuration
    parameter int SD_W     = 3;    // soft value width
    parameter int PM_W     = 16;   // path metric width
    parameter int MEM_BITS = 4;    // encoder memory, log2 of states

    // Derived sizes
    localparam int NSTATE = 1 << MEM_BITS;
    localparam int NBFLY  = NSTATE / 2;
    localparam int BM_W   = SD_W + 1;

    typedef logic signed [SD_W-1:0] soft_t;
    typedef logic signed [BM_W-1:0] bm_t;
    typedef logic signed [PM_W-1:0] pm_t;
    typedef pm_t [NSTATE-1:0]       pm_vec_t;
    typedef logic [MEM_BITS-1:0]    state_t;
    typedef logic [NSTATE-1:0]      trn_t;

    typedef struct packed {
        bm_t sum;
        bm_t diff;
    } bm_pair_t;

    typedef struct packed {
        pm_t  metric;
        logic dec;
    } acs_res_t;

    localparam pm_t PM_MAX = {1'b0, {(PM_W-1){1'b1}}};
    localparam pm_t PM_MIN = {1'b1, {(PM_W-1){1'b0}}};

    // Saturating a +/- b
    function automatic pm_t sat_add(pm_t a, bm_t b, logic neg);
        logic signed [PM_W:0] wa;
        logic signed [PM_W:0] wb;
        logic signed [PM_W:0] s;
        wa = {a[PM_W-1], a};
        wb = {{(PM_W+1-BM_W){b[BM_W-1]}}, b};
        if (neg) wb = -wb;
        s = wa + wb;
        if (s[PM_W] != s[PM_W-1])
            return s[PM_W] ? PM_MIN : PM_MAX;
        return s[PM_W-1:0];
    endfunction

    // Larger candidate wins; tie keeps the even predecessor
    function automatic acs_res_t acs_pick(pm_t from_even, pm_t from_odd);
        acs_res_t r;
        r.dec    = (from_odd > from_even);
        r.metric = r.dec ? from_odd : from_even;
        return r;
    endfunction

    function automatic pm_vec_t frame_init_vec();
        pm_vec_t v;
        for (int s = 0; s < NSTATE; s++)
            v[s] = (s == 0) ? '0 : PM_MIN;
        return v;
    endfunction

endpackage

// File: rtl/vit_branch_metric.sv
module vit_branch_metric
    import vit_acs_pkg::*;
(
    input  soft_t    sd0,
    input  soft_t    sd1,
    output bm_pair_t bm
);

    bm_t a_ext;
    bm_t b_ext;

    always_comb begin
        a_ext   = {sd0[SD_W-1], sd0};
        b_ext   = {sd1[SD_W-1], sd1};
        bm.sum  = a_ext + b_ext;
        bm.diff = a_ext - b_ext;
    end

endmodule

// File: rtl/vit_acs_butterfly.sv
module vit_acs_butterfly
    import vit_acs_pkg::*;
#(
    parameter bit REVERSE = 1'b0
)(
    input  pm_t  old_even,
    input  pm_t  old_odd,
    input  bm_t  m,
    output pm_t  new_lo,
    output pm_t  new_hi,
    output logic dec_lo,
    output logic dec_hi
);

    pm_t e_plus, e_minus, o_plus, o_minus;
    acs_res_t r_lo, r_hi;

    always_comb begin
        e_plus  = sat_add(old_even, m, 1'b0);
        e_minus = sat_add(old_even, m, 1'b1);
        o_plus  = sat_add(old_odd,  m, 1'b0);
        o_minus = sat_add(old_odd,  m, 1'b1);
    end

    generate
        if (!REVERSE) begin : g_direct
            always_comb begin
                r_lo = acs_pick(e_plus,  o_minus);
                r_hi = acs_pick(e_minus, o_plus);
            end
        end else begin : g_reverse
            always_comb begin
                r_lo = acs_pick(e_minus, o_plus);
                r_hi = acs_pick(e_plus,  o_minus);
            end
        end
    endgenerate

    assign new_lo = r_lo.metric;
    assign new_hi = r_hi.metric;
    assign dec_lo = r_lo.dec;
    assign dec_hi = r_hi.dec;

endmodule

// File: rtl/vit_metric_store.sv
module vit_metric_store
    import vit_acs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  logic    use_init,
    input  pm_vec_t new_pm,
    output pm_vec_t old_pm,
    input  state_t  rd_addr,
    output pm_t     rd_pm
);

    localparam pm_vec_t INIT_VEC = frame_init_vec();

    pm_vec_t bank_q [2];
    logic    cur_q;     // bank holding the latest stage

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q[0] <= INIT_VEC;
            bank_q[1] <= INIT_VEC;
            cur_q     <= 1'b0;
        end else if (wr_en) begin
            bank_q[~cur_q] <= new_pm;
            cur_q          <= ~cur_q;
        end
    end

    assign old_pm = use_init ? INIT_VEC : bank_q[cur_q];
    assign rd_pm  = bank_q[cur_q][rd_addr];

endmodule

// File: rtl/vit_acs_engine.sv
module vit_acs_engine
    import vit_acs_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sym_valid,
    input  logic                frame_start,
    input  logic [SD_W-1:0]     sd0,
    input  logic [SD_W-1:0]     sd1,
    input  logic [MEM_BITS-1:0] rd_state,
    output logic [PM_W-1:0]     rd_metric,
    output logic                trn_valid,
    output logic [NSTATE-1:0]   trn_word
);

    bm_pair_t bm;
    pm_vec_t  old_pm;
    pm_vec_t  new_pm;
    trn_t     dec_w;
    pm_t      rd_pm;
    trn_t     word_q;
    logic     valid_q;

    vit_branch_metric u_bm (
        .sd0 (soft_t'(sd0)),
        .sd1 (soft_t'(sd1)),
        .bm  (bm)
    );

    vit_metric_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (sym_valid),
        .use_init (frame_start),
        .new_pm   (new_pm),
        .old_pm   (old_pm),
        .rd_addr  (state_t'(rd_state)),
        .rd_pm    (rd_pm)
    );

    // One stage of butterflies; even index direct, odd reverse
    for (genvar j = 0; j < NBFLY; j++) begin : g_bfly
        bm_t m_j;
        assign m_j = (j < NBFLY/2) ? bm.sum : bm.diff;

        vit_acs_butterfly #(.REVERSE(j % 2 == 1)) u_bf (
            .old_even (old_pm[2*j]),
            .old_odd  (old_pm[2*j+1]),
            .m        (m_j),
            .new_lo   (new_pm[j]),
            .new_hi   (new_pm[j+NBFLY]),
            .dec_lo   (dec_w[NSTATE-1-2*j]),
            .dec_hi   (dec_w[NSTATE-2-2*j])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= sym_valid;
            if (sym_valid)
                word_q <= dec_w;
        end
    end

    assign trn_word  = word_q;
    assign trn_valid = valid_q;
    assign rd_metric = rd_pm;

endmodule

// File: rtl/vit_acs_checker.sv
module vit_acs_checker
    import vit_acs_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sym_valid,
    input logic                frame_start,
    input logic [SD_W-1:0]     sd0,
    input logic [SD_W-1:0]     sd1,
    input logic [MEM_BITS-1:0] rd_state,
    input logic [PM_W-1:0]     rd_metric,
    input logic                trn_valid,
    input logic [NSTATE-1:0]   trn_word
);

    p_valid_rise_r5: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> trn_valid);

    p_valid_low_r5: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> !trn_valid);

    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(trn_word));

    p_metric_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !sym_valid ##1 (rd_state == $past(rd_state)) |-> $stable(rd_metric));

    p_frame_head_r6: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && frame_start) |=> (trn_word[NSTATE-1 -: 2] == 2'b00));

    p_tie_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && frame_start && (sd0 == sd1))
            |=> (trn_word[NSTATE/2-1:0] == '0));

endmodule

bind vit_acs_engine vit_acs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .sym_valid   (sym_valid),
    .frame_start (frame_start),
    .sd0         (sd0),
    .sd1         (sd1),
    .rd_state    (rd_state),
    .rd_metric   (rd_metric),
    .trn_valid   (trn_valid),
    .trn_word    (trn_word)
);

// File: tb/tb_vit_acs_engine.sv
`timescale 1ns/1ps
module tb_vit_acs_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sym_valid = 1'b0;
    logic        frame_start = 1'b0;
    logic [2:0]  sd0 = '0;
    logic [2:0]  sd1 = '0;
    logic [3:0]  rd_state = '0;
    logic [15:0] rd_metric;
    logic        trn_valid;
    logic [15:0] trn_word;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference state
    int pm [16];
    int exp_word;
    int exp_valid;
    int addr_ctr = 0;

    always #2 clk = ~clk;

    vit_acs_engine dut (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .frame_start(frame_start),
        .sd0(sd0), .sd1(sd1), .rd_state(rd_state), .rd_metric(rd_metric),
        .trn_valid(trn_valid), .trn_word(trn_word)
    );

    function automatic int clamp16(int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < 16; s++) pm[s] = (s == 0) ? 0 : -32768;
        exp_word  = 0;
        exp_valid = 0;
    endtask

    // One trellis stage per the requirement text (R2, R3, R4, R6, R7)
    task automatic model_symbol(int a, int b, bit fs);
        int old [16];
        int nxt [16];
        int w;
        for (int s = 0; s < 16; s++) old[s] = fs ? ((s == 0) ? 0 : -32768) : pm[s];
        w = 0;
        for (int s = 0; s < 16; s++) begin
            int j, m, sg, ce, co, pos;
            j  = s % 8;
            m  = (j < 4) ? (a + b) : (a - b);
            sg = (j % 2 == 0) ? 1 : -1;
            if (s >= 8) sg = -sg;
            ce = clamp16(old[2*j] + sg*m);
            co = clamp16(old[2*j+1] - sg*m);
            pos = (s >= 8) ? (14 - 2*j) : (15 - 2*j);
            if (co > ce) begin
                nxt[s] = co;
                w = w | (1 << pos);
            end else begin
                nxt[s] = ce;
            end
        end
        for (int s = 0; s < 16; s++) pm[s] = nxt[s];
        exp_word = w;
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Called at a negedge: drive, let the edge pass, compare at next negedge
    task automatic cyc(bit v, bit fs, int a, int b, string req);
        sym_valid   = v;
        frame_start = fs;
        sd0         = a[2:0];
        sd1         = b[2:0];
        rd_state    = addr_ctr[3:0];
        addr_ctr++;
        @(posedge clk);
        exp_valid = v;
        if (v) model_symbol(a, b, fs);
        @(negedge clk);
        check(trn_valid == exp_valid[0], "R5", "trn_valid", int'(trn_valid), exp_valid);
        check(trn_word == exp_word[15:0], v ? req : "R9", "trn_word",
              int'(trn_word), exp_word);
        check($signed(rd_metric) == pm[rd_state], v ? req : "R8", "rd_metric",
              int'($signed(rd_metric)), pm[rd_state]);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state (R5, R6, R9)
        check(trn_valid == 1'b0, "R5", "reset trn_valid", int'(trn_valid), 0);
        check(trn_word == 16'h0, "R9", "reset trn_word", int'(trn_word), 0);
        rd_state = 4'd0; #0.1;
        check($signed(rd_metric) == 0, "R6", "reset metric s0", int'($signed(rd_metric)), 0);
        rd_state = 4'd11; #0.1;
        check($signed(rd_metric) == -32768, "R6", "reset metric s11",
              int'($signed(rd_metric)), -32768);
        @(negedge clk);
        rst = 1'b0;

        // R1: encoding extremes, including codes 011 and 100
        cyc(1, 1,  3,  3, "R1");
        cyc(1, 0, -4, -4, "R1");
        cyc(1, 0,  3, -4, "R1");
        cyc(1, 0, -4,  3, "R1");
        cyc(1, 0,  0, -1, "R1");
        cyc(1, 0, -1,  0, "R1");

        // R2: arbitrary symbol stream
        for (int i = 0; i < 60; i++)
            cyc(1, 0, $urandom_range(7) - 4, $urandom_range(7) - 4, "R2");

        // R4: alternating strong patterns exercising both halves of the word
        cyc(1, 1, 2, -3, "R4");
        for (int i = 0; i < 20; i++)
            cyc(1, 0, (i % 2) ? 3 : -4, (i % 3) ? -4 : 3, "R4");

        // R3: ties from zero branch metrics and equal soft values
        cyc(1, 1, 1, 1, "R3");
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0, "R3");
        cyc(1, 1, -2, -2, "R3");

        // R5, R8, R9: sparse symbols with idle reads across all states
        for (int i = 0; i < 48; i++) begin
            if (i % 3 == 0) cyc(1, 0, $urandom_range(7) - 4, $urandom_range(7) - 4, "R5");
            else            cyc(0, 0, 0, 0, "R8");
        end

        // R6: frame restart in the middle of a stream
        for (int i = 0; i < 10; i++) cyc(1, 0, 3, -1, "R6");
        cyc(1, 1, -3, 2, "R6");
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, "R6");

        // R7: long run driving metrics to the positive limit
        cyc(1, 1, 3, 3, "R7");
        for (int i = 0; i < 6000; i++) cyc(1, 0, 3, 3, "R7");
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 0, "R7");
        check(pm[0] == 32767, "R7", "model reached limit", pm[0], 32767);
        for (int i = 0; i < 40; i++)
            cyc(1, 0, $urandom_range(7) - 4, $urandom_range(7) - 4, "R7");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule